// File: doc/BRIEF.md
# Four-Source Selectable Rate Divider

This block chooses one of four source rate strobes and turns it into a slower enable pulse. Each source arrives as a one-cycle tick in the core clock domain, so a source that ticks every cycle stands for a full-rate clock. A 32-bit control word sets three things: which source is used, a second-stage ratio from 1 to 4, and a first-stage ratio from 1 to 32. The first stage is applied only when source 3 is selected. For sources 0 to 2 it is skipped, so the same control word can give a different overall ratio depending on the source.

The output `out_en` is high for one cycle on the selected-source tick that ends each output period. That period is the first-stage ratio times the second-stage ratio, counted in selected-source ticks. Software writes the control word at any time, but the new settings are adopted only on the cycle that ends the current period. When the source changes, a quiet handover of two cycles follows. During those two cycles neither the old nor the new source is counted, which matches the cost of a two-flop synchronised break-before-make switch.

Top module: `muxdiv_clk_en`

## Requirements
- R1: `rd_data` shows the last 32-bit word written with `wr_en`, every bit included, from the cycle after the write.
- R2: Bits [17:16] of the control word select which `src_tick` bit is counted (code n selects bit n). `out_en` is only ever high together with the tick of the active source.
- R3: Bits [5:4] hold the second-stage ratio minus one, giving ratios 1 to 4.
- R4: Bits [12:8] hold the first-stage ratio minus one, giving ratios 1 to 32. This stage applies only while source code 3 is active.
- R5: For source codes 0, 1 and 2, the first-stage field has no effect on `out_en`.
- R6: `out_en` is high for exactly one cycle, on the selected tick that completes a period of (first ratio × second ratio) selected ticks.
- R7: A written control word takes effect only after a cycle in which `out_en` is high. Until then, the current period runs with the ratios and source already in use.
- R8: When the adopted source code differs from the previous one, the two cycles that follow count no tick and produce no `out_en`.
- R9: While both ratios are 1, `out_en` equals the active source's tick in every cycle.
- R10: After reset the control word reads 0: source 0 with both ratios equal to 1.
- R11: Bits outside the three fields have no effect on `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| src_tick | input | 4 | One rate strobe per source |
| out_en | output | 1 | Divided enable pulse |

## Verification
The checker checks these on every cycle: that `out_en` coincides with the active source's tick, that the handover window stays quiet, that the adopted settings stay frozen outside period ends, that a ratio-1 setting passes the tick straight through, that the first-stage counter stays idle off source 3, and that the register reads back. Other properties need a reference model and long random runs. These are exact period lengths across products up to 128, deferral of writes made mid-period, and an ignored first-stage field on sources 0 to 2. The bench covers them by comparing against its behavioural model on every cycle.

// File: rtl/muxdiv_clk_en.sv
module muxdiv_clk_en #(
  parameter int GAP_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [3:0]  src_tick,
  output logic        out_en
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [1:0] PRE_SRC = 2'd3;

  logic [31:0]   ctrl_q;
  logic [1:0]    act_sel;
  logic [4:0]    act_pre;
  logic [1:0]    act_post;
  logic [4:0]    pre_cnt;
  logic [1:0]    post_cnt;
  logic [GW-1:0] gap_q;

  wire [1:0] nxt_sel  = ctrl_q[17:16];
  wire [4:0] nxt_pre  = ctrl_q[12:8];
  wire [1:0] nxt_post = ctrl_q[5:4];

  wire [4:0] pre_last = (act_sel == PRE_SRC) ? act_pre : 5'd0;
  wire       live     = (gap_q == '0) & src_tick[act_sel];
  wire       s1_done  = live & (pre_cnt == pre_last);

  assign out_en  = s1_done & (post_cnt == act_post);
  assign rd_data = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      act_sel  <= '0;
      act_pre  <= '0;
      act_post <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      gap_q    <= '0;
    end else begin
      if (wr_en) ctrl_q <= wr_data;
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (live) pre_cnt <= s1_done ? 5'd0 : pre_cnt + 5'd1;
      if (s1_done) post_cnt <= out_en ? 2'd0 : post_cnt + 2'd1;
      if (out_en) begin
        act_sel  <= nxt_sel;
        act_pre  <= nxt_pre;
        act_post <= nxt_post;
        if (nxt_sel != act_sel) gap_q <= GW'(GAP_CYCLES);
      end
    end
  end
endmodule

module muxdiv_clk_en_chk #(
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic [31:0]   rd_data,
  input logic [3:0]    src_tick,
  input logic          out_en,
  input logic [1:0]    act_sel,
  input logic [4:0]    act_pre,
  input logic [1:0]    act_post,
  input logic [4:0]    pre_cnt,
  input logic [GW-1:0] gap_q
);
  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  p_only_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> src_tick[act_sel]);

  p_bypass_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel != 2'd3) |-> (pre_cnt == 5'd0));

  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable({act_sel, act_pre, act_post}));

  p_quiet_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != '0) |-> !out_en);

  p_ratio1_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((gap_q == '0) && (act_post == 2'd0) && ((act_sel != 2'd3) || (act_pre == 5'd0)))
      |-> (out_en == src_tick[act_sel]));

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> rd_data == 32'd0);
endmodule

bind muxdiv_clk_en muxdiv_clk_en_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .src_tick(src_tick), .out_en(out_en),
  .act_sel(act_sel), .act_pre(act_pre), .act_post(act_post),
  .pre_cnt(pre_cnt), .gap_q(gap_q)
);

// File: tb/tb_muxdiv_clk_en.sv
`timescale 1ns/1ps
module tb_muxdiv_clk_en;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  src_tick = '0;
  logic        out_en;

  int tests = 0;
  int fails = 0;
  string cur_req = "R10";

  int unsigned m_reg;
  int m_sel, m_pre, m_post, m_cnt, m_gap;

  always #2.5 clk = ~clk;

  muxdiv_clk_en dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_tick(src_tick), .out_en(out_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_reg = 0; m_sel = 0; m_pre = 1; m_post = 1; m_cnt = 0; m_gap = 0;
  endtask

  task automatic step(input logic [3:0] tk, input logic we, input logic [31:0] d);
    bit valid, fire;
    int nsel;
    @(negedge clk);
    src_tick = tk; wr_en = we; wr_data = d;
    #1;
    valid = (m_gap == 0) && tk[m_sel];
    fire  = valid && (m_cnt + 1 == m_pre * m_post);
    check(cur_req, {31'd0, out_en}, {31'd0, fire});
    check("R1", rd_data, m_reg);
    if (m_gap > 0) m_gap--;
    if (valid) begin
      if (fire) begin
        m_cnt  = 0;
        nsel   = (m_reg >> 16) & 3;
        m_post = ((m_reg >> 4) & 3) + 1;
        m_pre  = (nsel == 3) ? ((m_reg >> 8) & 31) + 1 : 1;
        if (nsel != m_sel) m_gap = 2;
        m_sel  = nsel;
      end else m_cnt++;
    end
    if (we) m_reg = d;
  endtask

  function automatic logic [3:0] rnd_ticks();
    logic [3:0] t;
    t[0] = 1'b1;
    t[1] = ($urandom % 2) == 0;
    t[2] = ($urandom % 3) == 0;
    t[3] = ($urandom % 4) != 0;
    return t;
  endfunction

  task automatic run(input int n, input bit full);
    for (int i = 0; i < n; i++) step(full ? 4'hF : rnd_ticks(), 1'b0, '0);
  endtask

  task automatic write(input logic [31:0] d);
    step(rnd_ticks(), 1'b1, d);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", rd_data, 32'd0);
    rst_n = 1'b1;
    #1;
    src_tick = 4'h1;
    #0.5;
    check("R10", {31'd0, out_en}, 32'd1);

    cur_req = "R9";
    run(20, 1'b1);
    run(20, 1'b0);

    cur_req = "R11";
    write(32'hFFFC_E0CF);
    run(30, 1'b1);
    check("R1", rd_data, 32'hFFFC_E0CF);

    cur_req = "R3";
    write(32'h0000_0030);
    run(60, 1'b1);
    write(32'h0000_0010);
    run(40, 1'b0);

    cur_req = "R4";
    write(32'h0003_0310);
    run(250, 1'b0);

    cur_req = "R8";
    write(32'h0002_0000);
    run(30, 1'b1);
    write(32'h0003_0000);
    run(30, 1'b1);

    cur_req = "R5";
    write(32'h0001_1F10);
    run(150, 1'b0);
    write(32'h0000_1F00);
    run(40, 1'b1);

    cur_req = "R6";
    write(32'h0003_1F30);
    run(420, 1'b1);

    cur_req = "R7";
    for (int i = 0; i < 200; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ((i % 3) == 0) write(w); else run(1, 1'b0);
    end

    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      write(32'(s) << 16);
      run(60, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule